// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block holds a small set of request generator channels. Each channel produces DMA requests without any peripheral behind it. A channel watches one selected trigger line. When that line shows the chosen kind of edge, the channel issues a burst of requests toward the request router. The burst length is programmed. The router sees every generator output as one more request line that it can map to any DMA channel. This lets a signal from a device with no DMA support pace transfers, or lets one transfer chain into the next.

Each channel has its own control word. That word selects the trigger line, the edge mode, the burst length and the enables. Each request is a level that stays high until the consumer acknowledges it. A trigger edge that arrives while a burst is still open is an overrun. The overrun is recorded in a shared status word and can raise an interrupt. Software clears the recorded flags by writing ones to a shared clear address.

Top module: `dma_trig_reqgen`

## Requirements
- R1: After reset every request output and the interrupt are low. Every control word reads 0 and the status word reads 0.
- R2: The control word of generator g sits at byte address 0x100 + 4*g. Its fields are:
  - bits 4:0: trigger select
  - bit 8: interrupt enable
  - bit 16: generator enable
  - bits 18:17: edge mode
  - bits 23:19: burst count minus one

  The word reads back with these fields in place and with all other bits 0.
- R3: Each trigger line passes through two synchronizing flops before edge detection. A request rises in the third clock edge after the trigger input changes, and not before.
- R4: Edge mode 0 never fires. Mode 1 fires on a rising edge, mode 2 on a falling edge, and mode 3 on either edge.
- R5: The trigger select field chooses which trigger line a generator watches. A select value of N_TRIG or above never fires.
- R6: One trigger edge yields exactly count+1 requests. Each request is held high until a clock edge on which its acknowledge is high.
- R7: A write to a control word leaves the burst count field unchanged while the generator is enabled. The enable bit of that word, as it was before the write, decides this.
- R8: A write that clears the enable bit drops the request output at the same clock edge and abandons the burst. A later re-enable without a new trigger edge issues no request.
- R9: A qualifying trigger edge that arrives while a burst is open sets bit g of the status word at address 0x140.
- R10: Writing to address 0x144 clears each status bit whose data bit is 1. Bits written as 0 keep their value.
- R11: The interrupt output is high exactly when some status bit is set and that generator's interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| trig_in | input | N_TRIG | Asynchronous trigger lines |
| gen_req | output | N_GEN | Request level per generator |
| gen_ack | input | N_GEN | Acknowledge per generator |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The assertions cover the rules that hold on every cycle:
- A request only rises while its generator is enabled.
- A request never falls without an acknowledge or a disable.
- A status bit only rises while its generator has a request open.
- A status bit only falls after a clear write that names it.

The scenarios in the bench are needed for the rest:
- the exact three-edge trigger latency
- burst lengths
- each edge mode and out-of-range selects
- the count lock while enabled
- interrupt gating by the enable bit

// File: rtl/dma_trig_reqgen.sv
module dma_trig_reqgen #(
  parameter int N_GEN  = 4,
  parameter int N_TRIG = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [8:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [N_GEN-1:0]  gen_req,
  input  logic [N_GEN-1:0]  gen_ack,
  output logic              ovr_irq
);
  localparam logic [8:0] CTL_BASE = 9'h100;
  localparam logic [8:0] STAT_ADR = 9'h140;
  localparam logic [8:0] CLR_ADR  = 9'h144;

  logic [N_TRIG-1:0] sync1_q, sync2_q, last_q;
  logic [31:0] cur_w, old_w;

  logic [4:0] sel_q [N_GEN];
  logic [1:0] mode_q [N_GEN];
  logic [4:0] nb_q [N_GEN];
  logic [4:0] left_q [N_GEN];
  logic [N_GEN-1:0] ie_q, en_q, busy_q, ovr_set, ovr_q, clr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      last_q  <= '0;
    end else begin
      sync1_q <= trig_in;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
    end
  end

  assign cur_w = 32'(sync2_q);
  assign old_w = 32'(last_q);

  for (genvar g = 0; g < N_GEN; g++) begin : gen_ch
    logic wr_ctl, rise, fall, fire;

    assign wr_ctl = reg_we && (reg_addr == CTL_BASE + 9'(4 * g));
    assign rise   = cur_w[sel_q[g]] & ~old_w[sel_q[g]];
    assign fall   = ~cur_w[sel_q[g]] & old_w[sel_q[g]];
    assign fire   = en_q[g] && ((mode_q[g] == 2'd1 && rise) ||
                                (mode_q[g] == 2'd2 && fall) ||
                                (mode_q[g] == 2'd3 && (rise || fall)));
    assign ovr_set[g] = fire && busy_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[g]  <= '0;
        mode_q[g] <= '0;
        nb_q[g]   <= '0;
        ie_q[g]   <= 1'b0;
        en_q[g]   <= 1'b0;
      end else if (wr_ctl) begin
        sel_q[g]  <= reg_wdata[4:0];
        ie_q[g]   <= reg_wdata[8];
        en_q[g]   <= reg_wdata[16];
        mode_q[g] <= reg_wdata[18:17];
        if (!en_q[g]) nb_q[g] <= reg_wdata[23:19];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        left_q[g] <= '0;
      end else if (!en_q[g] || (wr_ctl && !reg_wdata[16])) begin
        busy_q[g] <= 1'b0;
      end else if (!busy_q[g]) begin
        if (fire) begin
          busy_q[g] <= 1'b1;
          left_q[g] <= nb_q[g];
        end
      end else if (gen_ack[g]) begin
        if (left_q[g] == '0) busy_q[g] <= 1'b0;
        else left_q[g] <= left_q[g] - 5'd1;
      end
    end
  end

  assign clr_mask = (reg_we && reg_addr == CLR_ADR) ? reg_wdata[N_GEN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) ovr_q <= '0;
    else        ovr_q <= (ovr_q & ~clr_mask) | ovr_set;
  end

  assign gen_req = busy_q;
  assign ovr_irq = |(ovr_q & ie_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADR) reg_rdata[N_GEN-1:0] = ovr_q;
    for (int g = 0; g < N_GEN; g++) begin
      if (reg_addr == CTL_BASE + 9'(4 * g))
        reg_rdata = {8'd0, nb_q[g], mode_q[g], en_q[g], 7'd0, ie_q[g], 3'd0, sel_q[g]};
    end
  end
endmodule

// File: rtl/dma_trig_reqgen_chk.sv
module dma_trig_reqgen_chk #(
  parameter int N_GEN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [8:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [N_GEN-1:0] gen_req,
  input logic [N_GEN-1:0] gen_ack,
  input logic [N_GEN-1:0] en_q,
  input logic [N_GEN-1:0] ovr_q
);
  logic [N_GEN-1:0] p_req, p_ack, p_en, p_flag, p_clr;
  logic             p_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_req   <= '0;
      p_ack   <= '0;
      p_en    <= '0;
      p_flag  <= '0;
      p_clr   <= '0;
      p_valid <= 1'b0;
    end else begin
      p_req   <= gen_req;
      p_ack   <= gen_ack;
      p_en    <= en_q;
      p_flag  <= ovr_q;
      p_clr   <= (reg_we && reg_addr == 9'h144) ? reg_wdata[N_GEN-1:0] : '0;
      p_valid <= 1'b1;
    end
  end

  // R8
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req & ~en_q) == '0);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> ((p_req & ~p_ack & p_en & en_q & ~gen_req) == '0));

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> ((ovr_q & ~p_flag & ~p_req) == '0));

  // R10
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> ((p_flag & ~ovr_q & ~p_clr) == '0));
endmodule

bind dma_trig_reqgen dma_trig_reqgen_chk #(.N_GEN(N_GEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .gen_req(gen_req), .gen_ack(gen_ack),
  .en_q(en_q), .ovr_q(ovr_q)
);

// File: tb/test_dma_trig_reqgen.sv
module test_dma_trig_reqgen;
  localparam int NG = 4;
  localparam int NT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NT-1:0] trig_in = '0;
  logic [NG-1:0] gen_req;
  logic [NG-1:0] gen_ack = '0;
  logic ovr_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_trig_reqgen #(.N_GEN(NG), .N_TRIG(NT)) i_dma_trig_reqgen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .gen_req(gen_req), .gen_ack(gen_ack), .ovr_irq(ovr_irq));

  function automatic logic [31:0] cw(int sel, bit ie, bit en, int mode, int nb);
    return {8'd0, 5'(nb), 2'(mode), en, 7'd0, ie, 3'd0, 5'(sel)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_trig(int i, bit v);
    @(negedge clk);
    trig_in[i] = v;
  endtask

  task automatic count_req(int g, int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (gen_req[g]) c++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 req", 32'(gen_req), 0);
    check("R1 irq", 32'(ovr_irq), 0);
    rd(9'h100, v); check("R1 ctrl0", v, 0);
    rd(9'h10C, v); check("R1 ctrl3", v, 0);
    rd(9'h140, v); check("R1 status", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(9'h104, 32'hFFFF_FFFF);
    rd(9'h104, v); check("R2 all ones", v, cw(31, 1, 1, 3, 31));
    wr(9'h104, 32'h0);
    wr(9'h104, cw(7, 1, 0, 2, 9));
    rd(9'h104, v); check("R2 fields", v, cw(7, 1, 0, 2, 9));
    wr(9'h104, 32'h0);
  endtask

  task automatic t_latency();
    wr(9'h100, cw(3, 0, 1, 1, 0));
    gen_ack[0] = 1'b0;
    set_trig(3, 1'b1);
    cyc(2); check("R3 not before third edge", 32'(gen_req[0]), 0);
    cyc(1); check("R3 third edge", 32'(gen_req[0]), 1);
    cyc(5); check("R6 held without ack", 32'(gen_req[0]), 1);
    gen_ack[0] = 1'b1;
    cyc(1); gen_ack[0] = 1'b0;
    check("R6 dropped after ack", 32'(gen_req[0]), 0);
    set_trig(3, 1'b0);
    cyc(5); check("R4 falling ignored in rising mode", 32'(gen_req[0]), 0);
  endtask

  task automatic t_burst();
    int c;
    wr(9'h100, 32'h0);
    wr(9'h100, cw(3, 0, 1, 1, 4));
    gen_ack[0] = 1'b1;
    set_trig(3, 1'b1);
    count_req(0, 40, c); check("R6 burst of five", 32'(c), 5);
    set_trig(3, 1'b0);
    cyc(5);
    wr(9'h100, 32'h0);
    wr(9'h100, cw(3, 0, 1, 1, 31));
    set_trig(3, 1'b1);
    count_req(0, 50, c); check("R6 burst of 32", 32'(c), 32);
    set_trig(3, 1'b0);
    cyc(5);
    gen_ack[0] = 1'b0;
  endtask

  task automatic t_modes();
    int c;
    gen_ack[0] = 1'b1;
    wr(9'h100, 32'h0);
    wr(9'h100, cw(3, 0, 1, 2, 0));
    set_trig(3, 1'b1); count_req(0, 10, c); check("R4 falling mode rise", 32'(c), 0);
    set_trig(3, 1'b0); count_req(0, 10, c); check("R4 falling mode fall", 32'(c), 1);
    wr(9'h100, cw(3, 0, 1, 3, 0));
    set_trig(3, 1'b1); count_req(0, 10, c); check("R4 both rise", 32'(c), 1);
    set_trig(3, 1'b0); count_req(0, 10, c); check("R4 both fall", 32'(c), 1);
    wr(9'h100, cw(3, 0, 1, 0, 0));
    set_trig(3, 1'b1); count_req(0, 10, c); check("R4 mode0 rise", 32'(c), 0);
    set_trig(3, 1'b0); count_req(0, 10, c); check("R4 mode0 fall", 32'(c), 0);
    gen_ack[0] = 1'b0;
  endtask

  task automatic t_select();
    int c;
    gen_ack[1] = 1'b1;
    wr(9'h104, cw(30, 0, 1, 3, 0));
    @(negedge clk); trig_in = '1;
    count_req(1, 10, c); check("R5 out of range rise", 32'(c), 0);
    @(negedge clk); trig_in = '0;
    count_req(1, 10, c); check("R5 out of range fall", 32'(c), 0);
    wr(9'h104, cw(5, 0, 1, 1, 0));
    set_trig(3, 1'b1); count_req(1, 10, c); check("R5 other line", 32'(c), 0);
    set_trig(5, 1'b1); count_req(1, 10, c); check("R5 selected line", 32'(c), 1);
    @(negedge clk); trig_in = '0;
    cyc(5);
    wr(9'h104, 32'h0);
    gen_ack[1] = 1'b0;
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(9'h100, 32'h0);
    wr(9'h100, cw(3, 0, 1, 1, 2));
    wr(9'h100, cw(3, 0, 1, 1, 7));
    rd(9'h100, v); check("R7 count kept while enabled", 32'(v[23:19]), 2);
    wr(9'h100, cw(3, 0, 0, 1, 7));
    rd(9'h100, v); check("R7 disabling write keeps count", 32'(v[23:19]), 2);
    wr(9'h100, cw(3, 0, 0, 1, 7));
    rd(9'h100, v); check("R7 count taken when disabled", 32'(v[23:19]), 7);
  endtask

  task automatic t_abort();
    gen_ack[0] = 1'b0;
    wr(9'h100, cw(3, 0, 1, 1, 5));
    set_trig(3, 1'b1);
    cyc(4); check("R8 burst open", 32'(gen_req[0]), 1);
    wr(9'h100, cw(3, 0, 0, 1, 5));
    check("R8 abort drops req", 32'(gen_req[0]), 0);
    wr(9'h100, cw(3, 0, 1, 1, 5));
    cyc(6); check("R8 re-enable no request", 32'(gen_req[0]), 0);
    set_trig(3, 1'b0);
    cyc(4);
    wr(9'h100, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    gen_ack[2] = 1'b0;
    wr(9'h108, cw(4, 1, 1, 1, 1));
    set_trig(4, 1'b1); cyc(4);
    check("R9 burst open", 32'(gen_req[2]), 1);
    rd(9'h140, v); check("R9 no flag on first edge", v, 0);
    set_trig(4, 1'b0); cyc(2);
    set_trig(4, 1'b1); cyc(4);
    rd(9'h140, v); check("R9 flag set", v, 32'h4);
    check("R11 irq with enable", 32'(ovr_irq), 1);
    wr(9'h144, 32'hB);
    rd(9'h140, v); check("R10 zero bits keep flag", v, 32'h4);
    wr(9'h144, 32'h4);
    rd(9'h140, v); check("R10 flag cleared", v, 0);
    check("R11 irq drops", 32'(ovr_irq), 0);
    wr(9'h108, cw(4, 0, 1, 1, 1));
    set_trig(4, 1'b0); cyc(2);
    set_trig(4, 1'b1); cyc(4);
    rd(9'h140, v); check("R9 flag again", v, 32'h4);
    check("R11 irq gated off", 32'(ovr_irq), 0);
    wr(9'h144, 32'h4);
    wr(9'h108, 32'h0);
    set_trig(4, 1'b0);
    cyc(4);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_readback();
    t_latency();
    t_burst();
    t_modes();
    t_select();
    t_lock();
    t_abort();
    t_overrun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule